// File: doc/BRIEF.md
# ADC Conversion Sequencer with Byte Register File

This block accepts byte-wide register writes from a host. It runs one analog-to-digital conversion each time software asks for one. Software first programs a handful of configuration bytes: a digital parameter byte, an averaging control, an 8-bit channel select and a 4-bit settle-delay code. It then turns the converter on and, in the same ascending burst of writes, sets a request bit as the final byte. After that request the sequencer waits out the settle delay, measured in microsecond ticks from a divided clock. It then pulls the configured number of samples from a valid/request sample port, averages them and places the 16-bit result in two byte registers, low byte first.

Completion is visible in two ways: an end-of-conversion status flag and a one-cycle interrupt pulse. If the sample source marks a sample as bad, the conversion ends at once with a fault flag, and the result bytes are left unchanged. Software treats a result as fresh only when the two low status bits read exactly 01 (done set, pending clear).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, status bytes 0x08 and 0x09 and result bytes 0x50 and 0x51 read 0x00, `irq` is low and offset 0x00 reads the REV_ID parameter.
- R2: Configuration bytes read back through masks: 0x42 keeps bits 6..2 (mask 0x7C), 0x43 keeps bit 7 and bits 2..0 (mask 0x87), 0x44 keeps all 8 bits and drives `mux_sel`, 0x45 keeps bits 3..0 and 0x46 keeps bit 7. Each write shows up on the cycle after its write edge.
- R3: A request is a write to 0x47 with bit 7 set while 0x46 bit 7 is set. On the next cycle 0x08 reads 0x02 (bit 1 pending set, bit 0 done clear, bit 7 fault clear) and 0x47 reads 0x80.
- R4: A request written while 0x46 bit 7 is clear changes nothing. Status stays 0x00, 0x47 reads 0x00 and `smp_req` stays low.
- R5: The settle time is set by code c = 0x45[3:0]. For c = 0 it is 15 us, for c = 1..7 it is c*100 us, and for c = 8..15 it is 1000 << (c-8) us. `smp_req` rises exactly settle_us * TICK_DIV cycles after the request write edge.
- R6: The number of samples is 2^N when 0x43 bit 7 is set, with N = 0x43[2:0]. Exactly one sample is taken when bit 7 is clear, whatever N is.
- R7: The result is the sum of the accepted samples shifted right by N, or the single sample when averaging is off. Offset 0x50 holds bits 7..0 and 0x51 holds bits 15..8.
- R8: On the edge that accepts the last sample, the result, done (0x08 = 0x01) and 0x47 = 0x00 all update together. `irq` is high for exactly that one following cycle.
- R9: A sample accepted with `smp_err` high ends the conversion. 0x08 then reads 0x80, `irq` pulses and the result bytes are unchanged. The next request clears the fault.
- R10: While a conversion is pending, writes to 0x42..0x46 are ignored. Writes to read-only offsets (0x00, 0x08, 0x09, 0x50, 0x51) are always ignored.
- R11: Offset 0x09 bits 6..4 give the sequence state: 0 when idle, 1 while settling, 2 while sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| mux_sel | output | 8 | Selected input channel |
| smp_req | output | 1 | Sequencer is waiting for samples |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Sample value |
| smp_err | input | 1 | Sample is faulty |
| irq | output | 1 | One-cycle completion or fault pulse |

## Verification
Every register write takes effect on the cycle after its write edge, and that includes the pending flag set by a request. `smp_req` is due exactly settle_us * TICK_DIV cycles after the request edge. Result, status and the interrupt all land on the cycle after the edge that accepts the last or faulty sample. The bench drives inputs on the falling edge and samples 3 ns after each rising edge. At each of those points it compares `irq`, `smp_req`, `mux_sel` and the addressed read byte with a behavioural model that advances on the same edges. Directed checks also count the settle cycles and compute the expected averages.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W       = 16;
    localparam int AVG_SH_W    = 3;
    localparam int MAX_SETTLE  = 128000;
    localparam int SETTLE_W    = $clog2(MAX_SETTLE + 1);
    localparam int SMP_CNT_W   = 8;

    localparam logic [7:0] OFS_REV    = 8'h00;
    localparam logic [7:0] OFS_STAT   = 8'h08;
    localparam logic [7:0] OFS_SEQ    = 8'h09;
    localparam logic [7:0] OFS_DIG    = 8'h42;
    localparam logic [7:0] OFS_AVG    = 8'h43;
    localparam logic [7:0] OFS_CHAN   = 8'h44;
    localparam logic [7:0] OFS_SETTLE = 8'h45;
    localparam logic [7:0] OFS_ENA    = 8'h46;
    localparam logic [7:0] OFS_REQ    = 8'h47;
    localparam logic [7:0] OFS_RES_LO = 8'h50;
    localparam logic [7:0] OFS_RES_HI = 8'h51;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SAMPLE = 3'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e             state;
        logic [7:0]             dig;
        logic [7:0]             avg;
        logic [7:0]             chan;
        logic [3:0]             settle;
        logic                   en;
        logic                   req;
        logic                   eoc;
        logic                   pend;
        logic                   fault;
        logic [RES_W-1:0]       res;
        logic [SETTLE_W-1:0]    wait_cnt;
        logic [SMP_CNT_W-1:0]   smp_cnt;
        logic                   irq;
    } seq_regs_t;

    // Settle code to microseconds: short linear range, then doubling milliseconds.
    function automatic logic [SETTLE_W-1:0] settle_us(input logic [3:0] code);
        if (code == 4'd0)
            return SETTLE_W'(15);
        else if (!code[3])
            return SETTLE_W'(int'(code) * 100);
        else
            return SETTLE_W'(1000 << code[2:0]);
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            logic unused_tick_in;
            assign unused_tick_in = ^{clk, rst_n, clr};
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = (cnt_q == W'(DIV - 1));
                cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
    parameter int IN_W = 16,
    parameter int SH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            add,
    input  logic [IN_W-1:0] din,
    input  logic [SH_W-1:0] shift,
    output logic [IN_W-1:0] avg_o
);
    localparam int ACC_W = IN_W + (1 << SH_W) - 1;

    logic [ACC_W-1:0] acc_d, acc_q, sum;

    always_comb begin
        sum   = acc_q + ACC_W'(din);
        avg_o = IN_W'(sum >> shift);
        acc_d = clr ? '0 : (add ? sum : acc_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int         TICK_DIV = 100,
    parameter logic [7:0] REV_ID   = 8'h35
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic [7:0]  mux_sel,
    output logic        smp_req,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        smp_err,
    output logic        irq
);
    seq_regs_t cur_q, nxt_d;

    logic                tick, tick_clr;
    logic                acc_clr, acc_add;
    logic [AVG_SH_W-1:0] avg_shift;
    logic [SMP_CNT_W-1:0] last_idx;
    logic [RES_W-1:0]    avg_out;
    logic                en_w, pend_w, eoc_w, fault_w;

    assign en_w    = cur_q.en;
    assign pend_w  = cur_q.pend;
    assign eoc_w   = cur_q.eoc;
    assign fault_w = cur_q.fault;

    adc_seq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    adc_seq_avg #(.IN_W(RES_W), .SH_W(AVG_SH_W)) u_avg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acc_clr),
        .add  (acc_add),
        .din  (smp_data),
        .shift(avg_shift),
        .avg_o(avg_out)
    );

    always_comb begin
        avg_shift = cur_q.avg[7] ? cur_q.avg[AVG_SH_W-1:0] : '0;
        last_idx  = cur_q.avg[7] ? ((SMP_CNT_W'(1) << cur_q.avg[AVG_SH_W-1:0]) - SMP_CNT_W'(1))
                                 : '0;
    end

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.irq = 1'b0;
        tick_clr = 1'b0;
        acc_clr  = 1'b0;
        acc_add  = 1'b0;
        case (cur_q.state)
            ST_SETTLE: begin
                if (tick) begin
                    if (cur_q.wait_cnt == SETTLE_W'(1)) begin
                        nxt_d.state   = ST_SAMPLE;
                        nxt_d.smp_cnt = '0;
                    end else begin
                        nxt_d.wait_cnt = cur_q.wait_cnt - SETTLE_W'(1);
                    end
                end
            end
            ST_SAMPLE: begin
                if (smp_valid) begin
                    if (smp_err) begin
                        nxt_d.fault = 1'b1;
                        nxt_d.pend  = 1'b0;
                        nxt_d.req   = 1'b0;
                        nxt_d.irq   = 1'b1;
                        nxt_d.state = ST_IDLE;
                    end else if (cur_q.smp_cnt == last_idx) begin
                        nxt_d.res   = avg_out;
                        nxt_d.eoc   = 1'b1;
                        nxt_d.pend  = 1'b0;
                        nxt_d.req   = 1'b0;
                        nxt_d.irq   = 1'b1;
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.smp_cnt = cur_q.smp_cnt + SMP_CNT_W'(1);
                        acc_add       = 1'b1;
                    end
                end
            end
            default: begin
                if (wr_en) begin
                    case (wr_addr)
                        OFS_DIG:    nxt_d.dig    = wr_data & 8'h7C;
                        OFS_AVG:    nxt_d.avg    = wr_data & 8'h87;
                        OFS_CHAN:   nxt_d.chan   = wr_data;
                        OFS_SETTLE: nxt_d.settle = wr_data[3:0];
                        OFS_ENA:    nxt_d.en     = wr_data[7];
                        OFS_REQ: begin
                            if (wr_data[7] && cur_q.en) begin
                                nxt_d.req      = 1'b1;
                                nxt_d.pend     = 1'b1;
                                nxt_d.eoc      = 1'b0;
                                nxt_d.fault    = 1'b0;
                                nxt_d.state    = ST_SETTLE;
                                nxt_d.wait_cnt = settle_us(cur_q.settle);
                                tick_clr       = 1'b1;
                                acc_clr        = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        case (rd_addr)
            OFS_REV:    rd_data = REV_ID;
            OFS_STAT:   rd_data = {fault_w, 5'b0, pend_w, eoc_w};
            OFS_SEQ:    rd_data = {1'b0, cur_q.state, 4'b0};
            OFS_DIG:    rd_data = cur_q.dig;
            OFS_AVG:    rd_data = cur_q.avg;
            OFS_CHAN:   rd_data = cur_q.chan;
            OFS_SETTLE: rd_data = {4'b0, cur_q.settle};
            OFS_ENA:    rd_data = {en_w, 7'b0};
            OFS_REQ:    rd_data = {cur_q.req, 7'b0};
            OFS_RES_LO: rd_data = cur_q.res[7:0];
            OFS_RES_HI: rd_data = cur_q.res[15:8];
            default:    rd_data = 8'h00;
        endcase
    end

    assign mux_sel = cur_q.chan;
    assign smp_req = (cur_q.state == ST_SAMPLE);
    assign irq     = cur_q.irq;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       smp_req,
    input logic       smp_valid,
    input logic       smp_err,
    input logic       irq,
    input logic       st_en,
    input logic       st_pend,
    input logic       st_eoc,
    input logic       st_fault
);
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_done_pulses_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_pend) |-> irq);

    p_status_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_eoc && st_pend));

    p_sample_only_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> st_pend);

    p_req_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_REQ && wr_data[7] && !st_en && !st_pend) |=> !st_pend);

    p_fault_ends_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && smp_valid && smp_err) |=> (st_fault && !st_pend && !st_eoc && irq));
endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .smp_req  (smp_req),
    .smp_valid(smp_valid),
    .smp_err  (smp_err),
    .irq      (irq),
    .st_en    (en_w),
    .st_pend  (pend_w),
    .st_eoc   (eoc_w),
    .st_fault (fault_w)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int TDIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
    logic [7:0]  rd_data, mux_sel;
    logic        smp_req, irq;
    logic        smp_valid = 1'b0, smp_err = 1'b0;
    logic [15:0] smp_data = 16'h0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.TICK_DIV(TDIV), .REV_ID(8'h35)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mux_sel(mux_sel), .smp_req(smp_req),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_err(smp_err), .irq(irq)
    );

    int n_vec = 0, n_bad = 0, cycles = 0;
    int stbl[16] = '{15, 100, 200, 300, 400, 500, 600, 700,
                     1000, 2000, 4000, 8000, 16000, 32000, 64000, 128000};

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int m_dig, m_avg, m_chan, m_settle, m_en, m_req, m_eoc, m_pend, m_fault, m_res;
    int m_phase, m_rem, m_cnt, m_sum, m_irq, m_ntot, m_sh;

    function automatic int m_view(input int a);
        case (a)
            8'h00: return 8'h35;
            8'h08: return (m_fault << 7) | (m_pend << 1) | m_eoc;
            8'h09: return m_phase << 4;
            8'h42: return m_dig;
            8'h43: return m_avg;
            8'h44: return m_chan;
            8'h45: return m_settle;
            8'h46: return m_en << 7;
            8'h47: return m_req << 7;
            8'h50: return m_res & 8'hFF;
            8'h51: return (m_res >> 8) & 8'hFF;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a == 8'h00) return "R1 revision";
        if (a == 8'h08 || a == 8'h09) return "R3 status";
        if (a == 8'h50 || a == 8'h51) return "R7 result";
        return "R2 config";
    endfunction

    always @(posedge clk) begin : ref_model
        if (!rst_n) begin
            m_dig = 0; m_avg = 0; m_chan = 0; m_settle = 0; m_en = 0; m_req = 0;
            m_eoc = 0; m_pend = 0; m_fault = 0; m_res = 0; m_phase = 0; m_rem = 0;
            m_cnt = 0; m_sum = 0; m_irq = 0; m_ntot = 1; m_sh = 0;
        end else begin
            m_irq = 0;
            if (m_phase == 2) begin
                if (smp_valid) begin
                    if (smp_err) begin
                        m_fault = 1; m_pend = 0; m_req = 0; m_irq = 1; m_phase = 0;
                    end else begin
                        m_sum = m_sum + int'(smp_data);
                        m_cnt++;
                        if (m_cnt == m_ntot) begin
                            m_res = (m_sum >> m_sh) & 16'hFFFF;
                            m_eoc = 1; m_pend = 0; m_req = 0; m_irq = 1; m_phase = 0;
                        end
                    end
                end
            end else if (m_phase == 1) begin
                m_rem--;
                if (m_rem == 0) m_phase = 2;
            end else if (wr_en) begin
                case (wr_addr)
                    8'h42: m_dig = int'(wr_data) & 8'h7C;
                    8'h43: m_avg = int'(wr_data) & 8'h87;
                    8'h44: m_chan = int'(wr_data);
                    8'h45: m_settle = int'(wr_data) & 8'h0F;
                    8'h46: m_en = int'(wr_data[7]);
                    8'h47: if (wr_data[7] && m_en == 1) begin
                        m_req = 1; m_pend = 1; m_eoc = 0; m_fault = 0; m_phase = 1;
                        m_rem = stbl[m_settle] * TDIV; m_cnt = 0; m_sum = 0;
                        m_ntot = m_avg[7] ? (1 << (m_avg & 7)) : 1;
                        m_sh = m_avg[7] ? (m_avg & 7) : 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-clock comparison and watchdog ----------------
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            cycles++;
            chk("R8 irq", int'(irq), m_irq);
            chk("R5 smp_req", int'(smp_req), int'(m_phase == 2));
            chk("R2 mux_sel", int'(mux_sel), m_chan);
            chk(tag_of(int'(rd_addr)), int'(rd_data), m_view(int'(rd_addr)));
            if (cycles > 150000) begin
                chk("watchdog expired", 1, 0);
                finish_run();
            end
        end
    end

    // ---------------- sample source ----------------
    int src_idx = 0, err_idx = -1, gap = 0;
    int base = 0;
    logic offered = 1'b0;

    function automatic int sval(input int b, input int i);
        return (b + i * 97) & 16'hFFFF;
    endfunction

    always @(negedge clk) begin
        if (!smp_req) src_idx = 0;
        else if (offered) src_idx++;
        gap++;
        if (smp_req && (gap % 3) != 1) begin
            smp_valid = 1'b1;
            smp_data  = 16'(sval(base, src_idx));
            smp_err   = (src_idx == err_idx);
            offered   = 1'b1;
        end else begin
            smp_valid = 1'b0;
            smp_err   = 1'b0;
            offered   = 1'b0;
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic setup(input logic [7:0] dg, input logic [7:0] av,
                         input logic [7:0] ch, input logic [7:0] st);
        wr(8'h42, dg); wr(8'h43, av); wr(8'h44, ch); wr(8'h45, st); wr(8'h46, 8'h80);
    endtask

    task automatic wait_irq(input string tag);
        int k = 0;
        while (irq !== 1'b1 && k < 20000) begin
            @(posedge clk); #3; k++;
        end
        chk(tag, int'(irq), 1);
    endtask

    task automatic measure_settle(input string tag, input int exp_cycles);
        int k = 0;
        #2;
        while (!smp_req && k < 10000) begin
            @(posedge clk); #3; k++;
        end
        chk(tag, k, exp_cycles);
    endtask

    function automatic int exp_avg(input int b, input int n, input int sh);
        int s = 0;
        for (int i = 0; i < n; i++) s += sval(b, i);
        return (s >> sh) & 16'hFFFF;
    endfunction

    // ---------------- directed sequence ----------------
    initial begin
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", int'(irq), 0);
        rd_chk("R1 status1", 8'h08, 8'h00);
        rd_chk("R1 status2", 8'h09, 8'h00);
        rd_chk("R1 result lo", 8'h50, 8'h00);
        rd_chk("R1 result hi", 8'h51, 8'h00);
        rd_chk("R1 revision", 8'h00, 8'h35);

        // R2 masked readback
        wr(8'h42, 8'hFF); rd_chk("R2 dig mask", 8'h42, 8'h7C);
        wr(8'h43, 8'hFF); rd_chk("R2 avg mask", 8'h43, 8'h87);
        wr(8'h44, 8'hA5); rd_chk("R2 chan", 8'h44, 8'hA5);
        chk("R2 mux_sel", int'(mux_sel), 8'hA5);
        wr(8'h45, 8'hF3); rd_chk("R2 settle mask", 8'h45, 8'h03);
        wr(8'h46, 8'hFF); rd_chk("R2 enable mask", 8'h46, 8'h80);
        wr(8'h46, 8'h7F); rd_chk("R2 enable clear", 8'h46, 8'h00);

        // R4 request with converter disabled
        wr(8'h47, 8'h80);
        rd_chk("R4 status stays idle", 8'h08, 8'h00);
        rd_chk("R4 request not held", 8'h47, 8'h00);
        rd_chk("R4 sequence idle", 8'h09, 8'h00);
        repeat (8) @(posedge clk);
        #3 chk("R4 no sampling", int'(smp_req), 0);

        // Conversion A: no averaging, shortest settle
        base = 16'h4000; err_idx = -1;
        setup(8'h34, 8'h00, 8'h11, 8'h00);
        wr(8'h47, 8'h80);
        rd_chk("R3 pending after request", 8'h08, 8'h02);
        rd_chk("R3 request readback", 8'h47, 8'h80);
        rd_chk("R11 settling code", 8'h09, 8'h10);
        wait_irq("R8 irq on completion A");
        @(posedge clk); #3 chk("R8 irq one cycle", int'(irq), 0);
        rd_chk("R8 done status", 8'h08, 8'h01);
        rd_chk("R8 request self-clear", 8'h47, 8'h00);
        rd_chk("R7 result A lo", 8'h50, exp_avg(16'h4000, 1, 0) & 8'hFF);
        rd_chk("R7 result A hi", 8'h51, exp_avg(16'h4000, 1, 0) >> 8);

        // Conversion B: 4 samples, millisecond settle code
        base = 16'h2000;
        setup(8'h00, 8'h82, 8'h22, 8'h08);
        wr(8'h47, 8'h80);
        measure_settle("R5 settle code 8", 1000 * TDIV);
        rd_chk("R11 sampling code", 8'h09, 8'h20);
        wait_irq("R8 irq on completion B");
        e = exp_avg(16'h2000, 4, 2);
        rd_chk("R7 result B lo", 8'h50, e & 8'hFF);
        rd_chk("R7 result B hi", 8'h51, e >> 8);

        // Conversion C: 128 samples
        base = 16'h0100;
        setup(8'h00, 8'h87, 8'h33, 8'h01);
        wr(8'h47, 8'h80);
        measure_settle("R5 settle code 1", 100 * TDIV);
        wait_irq("R6 irq after 128 samples");
        e = exp_avg(16'h0100, 128, 7);
        rd_chk("R6 result C lo", 8'h50, e & 8'hFF);
        rd_chk("R6 result C hi", 8'h51, e >> 8);

        // Conversion D: averaging off with nonzero count field -> one sample
        base = 16'h1234;
        setup(8'h00, 8'h05, 8'h44, 8'h02);
        wr(8'h47, 8'h80);
        measure_settle("R5 settle code 2", 200 * TDIV);
        wait_irq("R6 irq single sample");
        rd_chk("R6 single sample lo", 8'h50, 8'h34);
        rd_chk("R6 single sample hi", 8'h51, 8'h12);

        // Conversion E: fault on third sample, config locked while busy
        base = 16'h7000; err_idx = 2;
        setup(8'h00, 8'h83, 8'h55, 8'h03);
        wr(8'h47, 8'h80);
        wr(8'h45, 8'h0F); rd_chk("R10 settle locked", 8'h45, 8'h03);
        wr(8'h43, 8'h00); rd_chk("R10 avg locked", 8'h43, 8'h83);
        wr(8'h44, 8'h99); rd_chk("R10 chan locked", 8'h44, 8'h55);
        wait_irq("R9 irq on fault");
        rd_chk("R9 fault status", 8'h08, 8'h80);
        rd_chk("R9 request cleared", 8'h47, 8'h00);
        rd_chk("R9 result kept lo", 8'h50, 8'h34);
        rd_chk("R9 result kept hi", 8'h51, 8'h12);
        wr(8'h50, 8'hFF); rd_chk("R10 result read-only", 8'h50, 8'h34);
        wr(8'h08, 8'h03); rd_chk("R10 status read-only", 8'h08, 8'h80);

        // Conversion F: new request clears fault
        base = 16'h0800; err_idx = -1;
        setup(8'h00, 8'h81, 8'h66, 8'h00);
        wr(8'h47, 8'h80);
        rd_chk("R9 fault cleared by request", 8'h08, 8'h02);
        wait_irq("R8 irq on completion F");
        rd_chk("R8 done after fault", 8'h08, 8'h01);
        e = exp_avg(16'h0800, 2, 1);
        rd_chk("R7 result F lo", 8'h50, e & 8'hFF);
        rd_chk("R7 result F hi", 8'h51, e >> 8);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule